// File: doc/BRIEF.md
# PS/2 keyboard scan-code receiver

This block listens to a keyboard on a two-wire open-drain bus (a clock line and a data line, both resting high) and turns the byte stream it carries into key events. A fast system clock oversamples both lines. Each line passes through a two-flop synchroniser. The keyboard clock then passes through a glitch filter, and the data line is captured on each filtered falling edge of the keyboard clock. A frame has 11 bits: a low start bit, eight data bits sent least significant bit first, an odd parity bit and a high stop bit. The block checks the start bit, the parity and the stop bit of every frame.

Good bytes go to a small prefix decoder. The byte E0 marks an extended key and the byte F0 marks a release. Neither prefix produces an event. Instead, each sets a flag that is attached to the next ordinary code. That code leaves the block as a single-cycle event that carries the code, a release flag and an extended flag. A frame that fails any check is discarded. It raises a one-cycle error strobe and clears any pending prefix. If the keyboard clock stays high too long in the middle of a frame, the bit counter returns to idle so that the receiver can pick up the next frame cleanly. The block only ever listens and never drives the bus.

Top module: `ps2_scan_rx`

## Requirements
- R1: After reset, evt_valid, err_strobe, evt_code, evt_release and evt_extended are all 0.
- R2: A good frame carrying a byte other than E0 or F0, with no prefix pending, produces one evt_valid pulse with evt_code equal to the byte, evt_release=0 and evt_extended=0. Bit order on the wire is start(0), d0..d7, parity (chosen so that the 9 bits d0..d7 and parity hold an odd number of ones), stop(1).
- R3: A good F0 frame produces no event and makes the next event carry evt_release=1.
- R4: A good E0 frame produces no event and makes the next event carry evt_extended=1. The sequence E0, F0, code yields one event with both flags set.
- R5: Both prefix flags clear after each emitted event. A repeated make code produces a new event every time it arrives, each with both flags 0.
- R6: A frame with bad parity produces no event, gives a single-cycle err_strobe pulse and clears any pending prefix.
- R7: A frame whose start bit is 1, or whose stop bit is 0, is treated the same way as a frame with bad parity.
- R8: A low pulse on the keyboard clock that is shorter than FILT_LEN system-clock samples is ignored and does not disturb the frame in progress.
- R9: If the filtered keyboard clock stays high for more than TIMEOUT_CYC system cycles mid-frame, the partial frame is dropped with no event and no error, and the next full frame decodes correctly.
- R10: evt_valid and err_strobe are single-cycle pulses and are never high in the same cycle. No event ever carries code E0 or F0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| evt_valid | output | 1 | One-cycle strobe marking a key event |
| evt_code | output | 8 | Scan code of the event |
| evt_release | output | 1 | Event is a key release |
| evt_extended | output | 1 | Event is from an extended key |
| err_strobe | output | 1 | One-cycle strobe marking a dropped bad frame |

## Verification
A bit counter that is out of step with the bus does not fail quietly. It misreads the next frame, which shows up at the ports as an error strobe or a wrong code within that same frame. The timeout and glitch cases are aimed at exactly this fault. A prefix flag that is stuck set, or never set, shows up at the first event after the prefix as a wrong evt_release or evt_extended value. The bench therefore checks the flags on the event that follows every prefix, every error and every plain make code.

// File: rtl/ps2_scan_rx.sv
module ps2_scan_rx #(
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       evt_valid,
  output logic [7:0] evt_code,
  output logic       evt_release,
  output logic       evt_extended,
  output logic       err_strobe
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [1:0]    kc_s, kd_s;
  logic          kc_f, kc_fd;
  logic [FW-1:0] fcnt;
  logic [3:0]    bcnt;
  logic [TW-1:0] tcnt;
  logic [9:0]    sh;
  logic          ext_p, rel_p;

  wire       fall       = kc_fd & ~kc_f;
  wire       frame_done = fall && (bcnt == 4'd10);
  wire [7:0] code       = sh[8:1];
  wire       frame_ok   = ~sh[0] & (^sh[9:1]) & kd_s[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kc_s  <= 2'b11;
      kd_s  <= 2'b11;
      kc_f  <= 1'b1;
      kc_fd <= 1'b1;
      fcnt  <= '0;
    end else begin
      kc_s  <= {kc_s[0], ps2_clk_i};
      kd_s  <= {kd_s[0], ps2_dat_i};
      kc_fd <= kc_f;
      if (kc_s[1] == kc_f)
        fcnt <= '0;
      else if (fcnt == FW'(FILT_LEN - 1)) begin
        kc_f <= kc_s[1];
        fcnt <= '0;
      end else
        fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      tcnt <= '0;
      sh   <= '0;
    end else if (fall) begin
      tcnt <= '0;
      bcnt <= (bcnt == 4'd10) ? 4'd0 : bcnt + 4'd1;
      sh   <= {kd_s[1], sh[9:1]};
    end else if (bcnt != 4'd0 && kc_f) begin
      if (tcnt == TW'(TIMEOUT_CYC)) begin
        bcnt <= '0;
        tcnt <= '0;
      end else
        tcnt <= tcnt + 1'b1;
    end else
      tcnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid    <= 1'b0;
      evt_code     <= '0;
      evt_release  <= 1'b0;
      evt_extended <= 1'b0;
      err_strobe   <= 1'b0;
      ext_p        <= 1'b0;
      rel_p        <= 1'b0;
    end else begin
      evt_valid  <= 1'b0;
      err_strobe <= 1'b0;
      if (frame_done) begin
        if (!frame_ok) begin
          err_strobe <= 1'b1;
          ext_p      <= 1'b0;
          rel_p      <= 1'b0;
        end else if (code == 8'hE0)
          ext_p <= 1'b1;
        else if (code == 8'hF0)
          rel_p <= 1'b1;
        else begin
          evt_valid    <= 1'b1;
          evt_code     <= code;
          evt_extended <= ext_p;
          evt_release  <= rel_p;
          ext_p        <= 1'b0;
          rel_p        <= 1'b0;
        end
      end
    end
  end
endmodule

module ps2_scan_rx_chk #(
  parameter int TIMEOUT_CYC = 20000,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic          err_strobe,
  input logic [7:0]    evt_code,
  input logic          ext_p,
  input logic          rel_p,
  input logic [3:0]    bcnt,
  input logic [TW-1:0] tcnt
);
  assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |=> !err_strobe);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && err_strobe));
  assert_no_prefix_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code != 8'hE0 && evt_code != 8'hF0));
  assert_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (!ext_p && !rel_p));
  assert_err_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |-> (!ext_p && !rel_p));
  assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd10);
  assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= TW'(TIMEOUT_CYC));
endmodule

bind ps2_scan_rx ps2_scan_rx_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .err_strobe(err_strobe),
  .evt_code(evt_code), .ext_p(ext_p), .rel_p(rel_p), .bcnt(bcnt), .tcnt(tcnt)
);

// File: tb/sim_ps2_scan_rx.sv
`timescale 1ns/1ps
module sim_ps2_scan_rx;
  localparam int FILT = 4;
  localparam int TMO  = 300;
  localparam int HP   = 30;
  localparam int GAP  = 80;

  logic clk = 0, rst_n = 0, kclk = 1, kdat = 1;
  logic evt_valid, evt_release, evt_extended, err_strobe;
  logic [7:0] evt_code;
  int checks = 0, fails = 0;
  int evt_cnt = 0, err_cnt = 0, dbl = 0, both = 0;
  logic [7:0] l_code;
  logic l_rel, l_ext, pv, pe;

  always #2.5 clk = ~clk;

  ps2_scan_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_release(evt_release),
    .evt_extended(evt_extended), .err_strobe(err_strobe));

  initial begin pv = 0; pe = 0; end
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid) begin
        evt_cnt++; l_code = evt_code; l_rel = evt_release; l_ext = evt_extended;
      end
      if (err_strobe) err_cnt++;
      if ((evt_valid && pv) || (err_strobe && pe)) dbl++;
      if (evt_valid && err_strobe) both++;
      pv = evt_valid; pe = err_strobe;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [10:0] bits, input int nbits, input int glitch_bit);
    for (int i = 0; i < nbits; i++) begin
      kdat = bits[i];
      if (i == glitch_bit) begin
        cyc(10); kclk = 0; cyc(2); kclk = 1; cyc(HP - 12);
      end else cyc(HP);
      kclk = 0; cyc(HP); kclk = 1;
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit st,
                            input bit sp, input int glitch_bit);
    send_bits({sp, odd_par(b) ^ bad_par, b, st}, 11, glitch_bit);
    kdat = 1; cyc(GAP);
  endtask

  task automatic good(input logic [7:0] b);
    send_frame(b, 0, 0, 1, -1);
  endtask

  task automatic key(input bit ext, input bit rel, input logic [7:0] c, input string tag);
    int e0 = evt_cnt, r0 = err_cnt;
    if (ext) good(8'hE0);
    if (rel) good(8'hF0);
    chk(evt_cnt == e0, {tag, " prefix no event"}, evt_cnt, e0);
    good(c);
    chk(evt_cnt == e0 + 1 && err_cnt == r0, {tag, " one event"}, evt_cnt, e0 + 1);
    chk({l_ext, l_rel, l_code} == {ext, rel, c}, {tag, " event fields"},
        {l_ext, l_rel, l_code}, {ext, rel, c});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0, r0;
    void'($urandom(32'h5EED_2024));
    cyc(5); rst_n = 1; cyc(3);
    chk({evt_valid, err_strobe, evt_code, evt_release, evt_extended} == 0,
        "R1 reset outputs", {evt_valid, err_strobe, evt_code}, 0);

    key(0, 0, 8'h1C, "R2 plain make");
    key(0, 0, 8'h00, "R2 zero code");
    key(0, 1, 8'h1C, "R3 release");
    key(1, 0, 8'h75, "R4 extended");
    key(1, 1, 8'h6B, "R4 extended release");
    key(0, 0, 8'h1C, "R5 repeat make a");
    key(0, 0, 8'h1C, "R5 repeat make b");

    e0 = evt_cnt; r0 = err_cnt;
    good(8'hE0);
    send_frame(8'h1C, 1, 0, 1, -1);
    chk(err_cnt == r0 + 1 && evt_cnt == e0, "R6 bad parity error", err_cnt, r0 + 1);
    key(0, 0, 8'h1C, "R6 prefix cleared");

    r0 = err_cnt; e0 = evt_cnt;
    send_frame(8'h2B, 0, 1, 1, -1);
    chk(err_cnt == r0 + 1 && evt_cnt == e0, "R7 bad start", err_cnt, r0 + 1);
    good(8'hF0);
    send_frame(8'h2B, 0, 0, 0, -1);
    chk(err_cnt == r0 + 2 && evt_cnt == e0, "R7 bad stop", err_cnt, r0 + 2);
    key(0, 0, 8'h2B, "R7 prefix cleared");

    e0 = evt_cnt; r0 = err_cnt;
    send_frame(8'h5A, 0, 0, 1, 3);
    chk(evt_cnt == e0 + 1 && l_code == 8'h5A && err_cnt == r0, "R8 glitch ignored",
        l_code, 8'h5A);

    e0 = evt_cnt; r0 = err_cnt;
    send_bits({1'b1, 1'b0, 8'h55, 1'b0}, 5, -1);
    kdat = 1; cyc(TMO + 100);
    chk(evt_cnt == e0 && err_cnt == r0, "R9 partial dropped quietly", err_cnt, r0);
    key(0, 0, 8'h29, "R9 recovery");

    for (int it = 0; it < 40; it++) begin
      logic [7:0] c = 8'($urandom);
      bit x = 1'($urandom), r = 1'($urandom);
      if (c == 8'hE0 || c == 8'hF0) c = 8'h33;
      if ($urandom % 6 == 0) begin
        r0 = err_cnt; e0 = evt_cnt;
        send_frame(c, 1, 0, 1, -1);
        chk(err_cnt == r0 + 1 && evt_cnt == e0, "R6 random bad parity", err_cnt, r0 + 1);
      end else
        key(x, r, c, "R2 random key");
    end

    chk(dbl == 0, "R10 single-cycle strobes", dbl, 0);
    chk(both == 0, "R10 no overlap", both, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule